// File: doc/BRIEF.md
# Burst Read Memory Responder

This block answers read bursts from a bus master out of a small on-chip word array. A request carries a byte address, a beat count minus one, a beat size code, a burst type code and a transaction tag. It is taken on the request channel's valid/ready handshake. The block then streams the requested beats back on a response channel that has its own valid/ready handshake. The final beat is marked, the tag is echoed and an OKAY status is attached to every beat. Only one burst is in flight at a time. While it runs, the request channel is closed.

The request channel is open (ready high) whenever no burst is active, so a request can be taken in the same cycle its valid rises. Response beats come from a registered output stage. A beat is shown only after a request has been accepted. It stays frozen while the master withholds ready. The next beat is loaded in the same edge that retires the current one, so a master that keeps ready high gets one beat per cycle.

The array has no write path. On reset it fills with a fixed pattern: the word at index k (k zero-extended to 16 bits) holds {k ^ 16'h5A3C, ~k} for the default 32-bit data width. Each 32-bit lane of a wider word holds that same value.

Top module: `rd_mem_slave`

## Requirements
- R1: While rst_ni is low and after it is released with no request, req_ready_o is 1 and rsp_valid_o is 0.
- R2: A request is accepted on a rising edge where req_valid_i and req_ready_o are both 1. Its first beat is on the response port, with rsp_valid_o high, in the cycle right after that edge.
- R3: rsp_valid_o never rises unless a request was accepted on the previous edge or a burst is still running. With no request it stays 0 whatever rsp_ready_i does.
- R4: While rsp_valid_o is 1 and rsp_ready_i is 0, the next cycle keeps rsp_valid_o at 1 and leaves rsp_data_o, rsp_last_o and rsp_id_o unchanged.
- R5: req_ready_o is 0 from the cycle after acceptance until the final beat retires. It is 1 again in the cycle after that final response handshake.
- R6: A burst delivers exactly req_len_i+1 beats. rsp_last_o is 1 on the final beat only.
- R7: With burst code 2'b01 (incrementing), the byte address of beat n is the start address plus n*2^req_size_i, modulo 2^ADDR_W. Each beat returns the array word at index (byte address >> log2(DATA_W/8)).
- R8: With any burst code other than 2'b01, every beat of the burst reads the start address.
- R9: rsp_resp_o is 2'b00 on every valid beat, and rsp_id_o equals the req_id_i captured at acceptance.
- R10: If rsp_ready_i is held at 1, the beats of a burst appear on consecutive cycles with no idle cycle between them.
- R11: Request-channel activity while a burst runs is ignored. The running burst's beats are unaffected and no extra beat follows its last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken |
| req_addr_i | input | ADDR_W | Start byte address |
| req_len_i | input | LEN_W | Beats in burst minus one |
| req_size_i | input | 3 | log2 of bytes per beat |
| req_burst_i | input | 2 | Burst type, 2'b01 incrementing |
| req_id_i | input | ID_W | Transaction tag |
| rsp_valid_o | output | 1 | Beat present |
| rsp_ready_i | input | 1 | Master takes beat |
| rsp_data_o | output | DATA_W | Beat data |
| rsp_id_o | output | ID_W | Echoed tag |
| rsp_resp_o | output | 2 | Status, always OKAY |
| rsp_last_o | output | 1 | Final beat of burst |

## Verification
A corrupted remaining-beat counter shows as rsp_last_o on the wrong beat, or as a missing or extra beat, within the burst under test. A wrong address register shows as a data mismatch on the very next beat after the bad advance. A busy flag that fails to clear leaves req_ready_o low one cycle after the final handshake. An output stage that reloads while stalled changes rsp_data_o in the first stalled cycle. The bench compares every beat against the fill pattern under random backpressure, so each of these faults is caught in the cycle it happens.

// File: rtl/rd_slv_pkg.sv
package rd_slv_pkg;
  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;

  // reset fill pattern for one 32-bit lane
  function automatic logic [31:0] fill_lane(input logic [15:0] idx);
    return {idx ^ 16'h5A3C, ~idx};
  endfunction
endpackage

// File: rtl/rd_slv_ctrl.sv
module rd_slv_ctrl
  import rd_slv_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 8,
  parameter int ID_W   = 4,
  parameter int OFF_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [2:0]        req_size_i,
  input  logic [1:0]        req_burst_i,
  input  logic [ID_W-1:0]   req_id_i,
  output logic              req_ready_o,
  input  logic              beat_done_i,
  output logic              load_o,
  output logic [ADDR_W-OFF_W-1:0] rd_word_o,
  output logic              last_o,
  output logic [ID_W-1:0]   id_o
);
  logic              busy_q;
  logic [ADDR_W-1:0] cur_q, next_addr, rd_addr, incr;
  logic [LEN_W-1:0]  left_q;
  logic [2:0]        size_q;
  logic [1:0]        burst_q;
  logic [ID_W-1:0]   id_q;
  logic              accept, advance, finish;

  assign req_ready_o = !busy_q;
  assign accept      = req_valid_i && !busy_q;
  assign advance     = beat_done_i && (left_q != '0);
  assign finish      = beat_done_i && (left_q == '0);

  assign incr      = ADDR_W'(1) << size_q;
  assign next_addr = (burst_q == BURST_INCR) ? cur_q + incr : cur_q;
  assign rd_addr   = accept ? req_addr_i : next_addr;
  assign rd_word_o = rd_addr[ADDR_W-1:OFF_W];
  assign load_o    = accept || advance;
  assign last_o    = accept ? (req_len_i == '0) : (left_q == LEN_W'(1));
  assign id_o      = accept ? req_id_i : id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cur_q   <= '0;
      left_q  <= '0;
      size_q  <= '0;
      burst_q <= '0;
      id_q    <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      cur_q   <= rd_addr;
      left_q  <= req_len_i;
      size_q  <= req_size_i;
      burst_q <= req_burst_i;
      id_q    <= req_id_i;
    end else if (advance) begin
      cur_q  <= rd_addr;
      left_q <= left_q - LEN_W'(1);
    end else if (finish) begin
      busy_q <= 1'b0;
    end
  end

  // R5
  beat_needs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_done_i |-> busy_q);
  // R5
  reopen_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish |=> req_ready_o);
  // R11
  no_reaccept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !finish |=> busy_q && $stable(id_q));
endmodule

// File: rtl/rd_slv_mem.sv
module rd_slv_mem
  import rd_slv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int WORDS = 1 << IDX_W;
  localparam int LANES = DATA_W / 32;

  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= {LANES{fill_lane(16'(i))}};
    end
  end

  assign data_o = mem_q[idx_i];

  initial begin
    width_ok_chk: assert (DATA_W % 32 == 0 && DATA_W >= 32);
  end
endmodule

// File: rtl/rd_slv_rbuf.sv
module rd_slv_rbuf #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o,
  output logic [ID_W-1:0]   id_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      last_o  <= 1'b0;
      id_o    <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      last_o  <= last_i;
      id_o    <= id_i;
    end else if (done_i) begin
      valid_o <= 1'b0;
    end
  end

  // R4
  hold_when_stalled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o) && $stable(last_o) && $stable(id_o));
  // R10
  no_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && !last_o |=> valid_o);
endmodule

// File: rtl/rd_mem_slave.sv
module rd_mem_slave
  import rd_slv_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  parameter int ID_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [2:0]        req_size_i,
  input  logic [1:0]        req_burst_i,
  input  logic [ID_W-1:0]   req_id_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [ID_W-1:0]   rsp_id_o,
  output logic [1:0]        rsp_resp_o,
  output logic              rsp_last_o
);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int IDX_W = ADDR_W - OFF_W;

  logic              beat_done, load, last_nx;
  logic [IDX_W-1:0]  rd_word;
  logic [DATA_W-1:0] rd_data;
  logic [ID_W-1:0]   id_nx;

  assign beat_done  = rsp_valid_o && rsp_ready_i;
  assign rsp_resp_o = RESP_OKAY;

  rd_slv_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ID_W(ID_W), .OFF_W(OFF_W)) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .req_len_i, .req_size_i,
    .req_burst_i, .req_id_i, .req_ready_o,
    .beat_done_i(beat_done), .load_o(load), .rd_word_o(rd_word),
    .last_o(last_nx), .id_o(id_nx)
  );

  rd_slv_mem #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
    .clk_i, .rst_ni, .idx_i(rd_word), .data_o(rd_data)
  );

  rd_slv_rbuf #(.DATA_W(DATA_W), .ID_W(ID_W)) u_rbuf (
    .clk_i, .rst_ni, .load_i(load), .done_i(beat_done), .data_i(rd_data),
    .last_i(last_nx), .id_i(id_nx), .ready_i(rsp_ready_i),
    .valid_o(rsp_valid_o), .data_o(rsp_data_o), .last_o(rsp_last_o), .id_o(rsp_id_o)
  );

  // R3
  valid_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) |-> $past(req_valid_i && req_ready_o));
  // R2
  first_beat_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> rsp_valid_o);
  // R5
  closed_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);
  // R9
  resp_okay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_resp_o == 2'b00);
endmodule

// File: tb/sim_rd_mem_slave.sv
module sim_rd_mem_slave;
  localparam int ADDR_W = 10, DATA_W = 32, LEN_W = 8, ID_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [2:0]        req_size = '0;
  logic [1:0]        req_burst = '0;
  logic [ID_W-1:0]   req_id = '0;
  logic              req_ready, rsp_valid, rsp_last;
  logic [DATA_W-1:0] rsp_data;
  logic [ID_W-1:0]   rsp_id;
  logic [1:0]        rsp_resp;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  rd_mem_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .ID_W(ID_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_size_i(req_size),
    .req_burst_i(req_burst), .req_id_i(req_id), .rsp_valid_o(rsp_valid),
    .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data), .rsp_id_o(rsp_id),
    .rsp_resp_o(rsp_resp), .rsp_last_o(rsp_last)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [ADDR_W-1:0] a0, input int k,
                                           input logic [2:0] sz, input logic [1:0] bt);
    logic [ADDR_W-1:0] a;
    logic [15:0] idx;
    a = (bt == 2'b01) ? ADDR_W'(a0 + ADDR_W'(k) * (ADDR_W'(1) << sz)) : a0;
    idx = 16'(a >> 2);
    return {idx ^ 16'h5A3C, ~idx};
  endfunction

  function automatic bit next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // R1
  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", 64'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "valid in reset", 64'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "idle after reset",
        64'({req_ready, rsp_valid}), 64'b10);
  endtask

  // R3
  task automatic t_idle();
    for (int i = 0; i < 8; i++) begin
      req_addr = ADDR_W'(i * 37);
      rsp_ready = next_rand();
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R3", "valid without request", 64'(rsp_valid), 0);
    end
    rsp_ready = 1'b0;
  endtask

  // mode 0: ready held high, 1: random stalls, 2: random stalls plus requests during burst
  task automatic t_burst(input logic [ADDR_W-1:0] a0, input logic [LEN_W-1:0] len,
                         input logic [2:0] sz, input logic [1:0] bt,
                         input logic [ID_W-1:0] id, input int mode);
    int k = 0, guard = 0;
    bit stalled = 0, r;
    logic [DATA_W-1:0] p_data = '0;
    logic p_last = 0;
    logic [ID_W-1:0] p_id = '0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "ready before request", 64'(req_ready), 1);
    req_valid = 1'b1; req_addr = a0; req_len = len; req_size = sz;
    req_burst = bt; req_id = id; rsp_ready = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R2", "first beat cycle after accept", 64'(rsp_valid), 1);
    if (mode == 2) begin
      req_addr = a0 + 10'h155; req_id = ~id; req_len = 8'd3; req_burst = 2'b01;
    end else req_valid = 1'b0;
    while (k <= int'(len) && guard < 2000) begin
      guard++;
      chk(req_ready == 1'b0, "R5", "ready low during burst", 64'(req_ready), 0);
      if (mode == 0)
        chk(rsp_valid == 1'b1, "R10", "beat every cycle", 64'(rsp_valid), 1);
      if (rsp_valid) begin
        chk(rsp_data == exp_word(a0, k, sz, bt), (bt == 2'b01) ? "R7" : "R8",
            $sformatf("data beat %0d", k), 64'(rsp_data), 64'(exp_word(a0, k, sz, bt)));
        chk(rsp_last == (k == int'(len)), "R6", $sformatf("last beat %0d", k),
            64'(rsp_last), 64'(k == int'(len)));
        chk(rsp_id == id && rsp_resp == 2'b00, "R9", "id/resp",
            64'({rsp_id, rsp_resp}), 64'({id, 2'b00}));
        if (mode == 2)
          chk(rsp_id == id, "R11", "tag unaffected by late request", 64'(rsp_id), 64'(id));
      end
      if (stalled)
        chk(rsp_valid && rsp_data == p_data && rsp_last == p_last && rsp_id == p_id,
            "R4", "stable while stalled", 64'(rsp_data), 64'(p_data));
      r = (mode == 0) ? 1'b1 : next_rand();
      rsp_ready = r;
      p_data = rsp_data; p_last = rsp_last; p_id = rsp_id;
      if (rsp_valid && r) begin
        if (k == int'(len)) req_valid = 1'b0;
        k++;
        stalled = 0;
      end else stalled = rsp_valid;
      @(negedge clk);
    end
    chk(req_ready == 1'b1, "R5", "ready returns after last beat", 64'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R6", "no beat after last", 64'(rsp_valid), 0);
    rsp_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(rsp_valid == 1'b0, (mode == 2) ? "R11" : "R3", "quiet after burst", 64'(rsp_valid), 0);
    end
  endtask

  initial begin
    t_reset();
    t_idle();
    t_burst(10'h010, 8'd0, 3'd2, 2'b01, 4'h3, 0);   // single beat
    t_burst(10'h020, 8'd7, 3'd2, 2'b01, 4'h5, 0);   // back-to-back beats
    t_burst(10'h100, 8'd15, 3'd2, 2'b01, 4'hA, 1);  // random stalls
    t_burst(10'h041, 8'd9, 3'd0, 2'b01, 4'h1, 1);   // byte size
    t_burst(10'h082, 8'd6, 3'd1, 2'b01, 4'h2, 1);   // halfword size
    t_burst(10'h3F0, 8'd7, 3'd2, 2'b01, 4'h6, 1);   // address wrap
    t_burst(10'h0C8, 8'd4, 3'd2, 2'b00, 4'h9, 1);   // non-incrementing
    t_burst(10'h0CC, 8'd3, 3'd2, 2'b10, 4'hB, 0);   // other code holds
    t_burst(10'h200, 8'd11, 3'd2, 2'b01, 4'hC, 2);  // requests during burst
    t_burst(10'h204, 8'd63, 3'd2, 2'b01, 4'hF, 1);  // long burst
    finish_run();
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(1'b0, "WDOG", "watchdog expired", 64'(cyc), 100000);
        finish_run();
      end
    end
  end
endmodule